// File: doc/BRIEF.md
# Serial Flash Identification Probe

This block works out, by itself, the geometry of a paged serial flash that sits on its SPI pins. Once reset is released it runs one fixed identification sequence over an internal SPI shifter. When that sequence ends, it holds the number of pages, the page size in bytes and the page address shift. The rest of the chip uses these values to form flash addresses. The block uses no host and needs no configuration.

The sequence has two stages. First it sends an identification read that returns a manufacturer byte and two device bytes. If the manufacturer is the expected vendor, the device bytes pick a geometry family. For the families that can be switched between binary and non-binary page sizes, a status read follows, and status bit 0 decides which page size applies. If the manufacturer does not match, the block falls back to a status read and decodes a density code from status bits 5:2. A device that neither stage recognises raises an unsupported flag in place of the valid flag.

Top module: `flash_id_probe`

## Requirements
- R1: After reset is released, the block starts probing on its own. It drives `spi_cs_n` low and sends opcode 0x9F. It clocks three more bytes in, then raises `spi_cs_n`.
- R2: The SPI bus uses mode 0. `spi_sck` is low whenever `spi_cs_n` is high. MISO is sampled on the rising edge of `spi_sck`. `spi_mosi` changes only while `spi_sck` is low.
- R3: The ID path is taken when the first ID byte equals 0x1F and the two device bytes form an accepted code. For a code that offers both page sizes, a second transaction sends status opcode 0xD7 and reads one byte. Status bit 0 = 1 selects the binary page size and shift. Bit 0 = 0 selects the non-binary page size and shift.
- R4: On the ID path, the first device byte selects the geometry when the second device byte is 0x00, and also for code 0x2701. The page counts are: 0x22 → 512, 0x23 → 1024, 0x24 → 2048, 0x25 → 4096, 0x26 → 4096, 0x27 → 8192, 0x28 → 8192. The page sizes are: for 0x22–0x25, 264 bytes with shift 9, or binary 256 bytes with shift 8; for 0x26 and 0x27, 528 bytes with shift 10, or binary 512 bytes with shift 9; for 0x28, 1056 bytes with shift 11, or binary 1024 bytes with shift 10.
- R5: Code 0x2700 gives 8192 pages of 528 bytes with shift 10. No status transaction is made for it.
- R6: When the first ID byte is not 0x1F, one status transaction (0xD7) follows. The status byte ANDed with 0x3C decodes as follows: 0x0C → 512×264, 0x14 → 1024×264, 0x1C → 2048×264, 0x24 → 4096×264, all with shift 9; 0x2C → 4096×528 and 0x34 → 8192×528, with shift 10; 0x38 or 0x3C → 8192×1056, with shift 11.
- R7: In the fallback path, a status byte of 0x00 or 0xFF means no device. It raises `dev_unsupported`.
- R8: An ID code outside R4/R5, or a density code outside R6, raises `dev_unsupported`, and `geo_valid` stays low.
- R9: `geo_valid` and `dev_unsupported` are never both high. Once either is set, it holds, together with the geometry outputs, until the next reset, and `spi_cs_n` stays high.
- R10: `found_by_id` is 1 when the geometry came from the ID path and 0 when it came from the status density code.
- R11: While reset is applied and while probing is in progress, `geo_valid` and `dev_unsupported` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; release starts a probe |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| geo_valid | output | 1 | Geometry outputs are valid |
| dev_unsupported | output | 1 | No device, or device not recognised |
| found_by_id | output | 1 | Identification came from the ID read |
| geo_pages | output | 14 | Number of pages |
| geo_page_bytes | output | 11 | Bytes per page |
| geo_addr_shift | output | 4 | Bit position of the page number in a flash address |

## Verification
A behavioural flash on the bench answers the ID and status opcodes with programmed bytes. Three groups of directed cases are run: every accepted device code with status bit 0 both set and clear, which separates the binary and non-binary page sizes; code 0x2700 with bit 0 set, which shows that no status read is made; and a foreign manufacturer with every density code, including 0x00, 0xFF and an unlisted code, which exercises the fallback decode and the no-device rejection. Random vendor, device and status bytes are then mixed in, and each case is compared against a bench model of the tables. The transaction count and opcodes seen by the flash show which path was taken.

// File: rtl/flashid_pkg.sv
// Shared widths, opcodes and the geometry record for the flash ID probe.
// Assumes the largest part has 8192 pages of at most 1056 bytes.
package flashid_pkg;
    localparam int PAGES_W = 14;
    localparam int BYTES_W = 11;
    localparam int SHIFT_W = 4;

    localparam logic [7:0] OPC_READ_ID = 8'h9F;
    localparam logic [7:0] OPC_STATUS  = 8'hD7;
    localparam logic [7:0] VENDOR_CODE = 8'h1F;
    localparam logic [7:0] DENSITY_MSK = 8'h3C;

    typedef struct packed {
        logic [PAGES_W-1:0] pages;
        logic [BYTES_W-1:0] bytes;
        logic [SHIFT_W-1:0] shift;
    } geom_t;
endpackage

// File: rtl/spi_byte_xfer.sv
// Mode-0 SPI byte shifter. A one-cycle start pulse, seen while idle, shifts
// tx_byte out MSB first and collects eight MISO bits into rx_byte. done
// pulses for one cycle after the last falling SCK edge. Chip select is
// driven by the caller. Assumes HALF_DIV >= 1 system clocks per SCK half.
module spi_byte_xfer #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(HALF_DIV - 1);

    logic             busy;
    logic             sck_q;
    logic             mosi_q;
    logic             done_q;
    logic [7:0]       sh_q;
    logic [7:0]       rx_q;
    logic [2:0]       bit_q;
    logic [CNT_W-1:0] div_q;

    // Bit timing: load on start, sample on SCK rise, advance on SCK fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            sck_q  <= 1'b0;
            mosi_q <= 1'b0;
            done_q <= 1'b0;
            sh_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            div_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    sh_q   <= tx_byte;
                    mosi_q <= tx_byte[7];
                    bit_q  <= '0;
                    div_q  <= '0;
                    sck_q  <= 1'b0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy   <= 1'b0;
                        done_q <= 1'b1;
                        mosi_q <= 1'b0;
                    end else begin
                        bit_q  <= bit_q + 3'd1;
                        sh_q   <= {sh_q[6:0], 1'b0};
                        mosi_q <= sh_q[6];
                    end
                end
            end else begin
                div_q <= div_q + CNT_W'(1);
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = mosi_q;
    assign rx_byte = rx_q;
    assign done    = done_q;
endmodule

// File: rtl/dev_code_lookup.sv
// Maps the two device bytes of an ID read to a geometry family. It gives
// both page-size variants, and tells whether a status read is needed to
// choose between them. Purely combinational.
module dev_code_lookup
    import flashid_pkg::*;
(
    input  logic [15:0] dev_code,
    output logic        hit,
    output logic        needs_status,
    output geom_t       geo_odd,
    output geom_t       geo_pow2
);
    logic               fam_known;
    logic [1:0]         size_cls;
    logic [PAGES_W-1:0] pages;

    // Family decode from the first device byte.
    always_comb begin
        fam_known = 1'b1;
        size_cls  = 2'd0;
        pages     = '0;
        case (dev_code[15:8])
            8'h22: pages = PAGES_W'(512);
            8'h23: pages = PAGES_W'(1024);
            8'h24: pages = PAGES_W'(2048);
            8'h25: pages = PAGES_W'(4096);
            8'h26: begin pages = PAGES_W'(4096); size_cls = 2'd1; end
            8'h27: begin pages = PAGES_W'(8192); size_cls = 2'd1; end
            8'h28: begin pages = PAGES_W'(8192); size_cls = 2'd2; end
            default: fam_known = 1'b0;
        endcase
    end

    // Accept listed codes and build both variants from the size class.
    always_comb begin
        hit           = fam_known && ((dev_code[7:0] == 8'h00) || (dev_code == 16'h2701));
        needs_status  = hit && (dev_code != 16'h2700);
        geo_odd.pages  = pages;
        geo_odd.bytes  = BYTES_W'(264) << size_cls;
        geo_odd.shift  = SHIFT_W'(9) + SHIFT_W'(size_cls);
        geo_pow2.pages = pages;
        geo_pow2.bytes = BYTES_W'(256) << size_cls;
        geo_pow2.shift = SHIFT_W'(8) + SHIFT_W'(size_cls);
    end
endmodule

// File: rtl/density_lookup.sv
// Fallback decode of the density code held in status bits 5:2. It rejects
// the all-zero and all-one status values that a missing device returns.
// Purely combinational.
module density_lookup
    import flashid_pkg::*;
(
    input  logic [7:0] status,
    output logic       hit,
    output geom_t      geo
);
    // Density code to geometry, with the no-device values rejected first.
    always_comb begin
        hit = 1'b1;
        geo = '0;
        if ((status == 8'h00) || (status == 8'hFF)) begin
            hit = 1'b0;
        end else begin
            case (status & DENSITY_MSK)
                8'h0C: geo = '{PAGES_W'(512),  BYTES_W'(264),  SHIFT_W'(9)};
                8'h14: geo = '{PAGES_W'(1024), BYTES_W'(264),  SHIFT_W'(9)};
                8'h1C: geo = '{PAGES_W'(2048), BYTES_W'(264),  SHIFT_W'(9)};
                8'h24: geo = '{PAGES_W'(4096), BYTES_W'(264),  SHIFT_W'(9)};
                8'h2C: geo = '{PAGES_W'(4096), BYTES_W'(528),  SHIFT_W'(10)};
                8'h34: geo = '{PAGES_W'(8192), BYTES_W'(528),  SHIFT_W'(10)};
                8'h38,
                8'h3C: geo = '{PAGES_W'(8192), BYTES_W'(1056), SHIFT_W'(11)};
                default: hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/flash_id_probe.sv
// Top of the flash identification probe. After reset release it runs an ID
// read, then a status read where one is needed, and latches the geometry
// or an unsupported flag. Results are held until the next reset. Assumes
// one flash on the bus, which answers opcodes 0x9F and 0xD7 in SPI mode 0.
module flash_id_probe
    import flashid_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_miso,
    output logic               spi_cs_n,
    output logic               spi_sck,
    output logic               spi_mosi,
    output logic               geo_valid,
    output logic               dev_unsupported,
    output logic               found_by_id,
    output logic [PAGES_W-1:0] geo_pages,
    output logic [BYTES_W-1:0] geo_page_bytes,
    output logic [SHIFT_W-1:0] geo_addr_shift
);
    localparam int ID_BYTES = 3;

    typedef enum logic [2:0] {
        ST_LAUNCH, ST_ID_SHIFT, ST_ID_JUDGE,
        ST_SR_LAUNCH, ST_SR_SHIFT, ST_SR_JUDGE, ST_FINISHED
    } phase_t;

    phase_t      phase_q;
    logic        cs_n_q;
    logic        kick_q;
    logic [7:0]  tx_q;
    logic [1:0]  byte_q;
    logic [23:0] id_q;
    logic [7:0]  sr_q;
    logic        via_id_q;
    logic        valid_q;
    logic        bad_q;
    geom_t       geo_q;

    logic        x_done;
    logic [7:0]  x_rx;
    logic        id_hit, id_needs_sr, dens_hit;
    geom_t       id_geo_odd, id_geo_pow2, dens_geo;

    spi_byte_xfer #(.HALF_DIV(HALF_DIV)) u_xfer (
        .clk(clk), .rst_n(rst_n), .start(kick_q), .tx_byte(tx_q),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .rx_byte(x_rx), .done(x_done)
    );

    dev_code_lookup u_devtab (
        .dev_code(id_q[15:0]), .hit(id_hit), .needs_status(id_needs_sr),
        .geo_odd(id_geo_odd), .geo_pow2(id_geo_pow2)
    );

    density_lookup u_denstab (
        .status(sr_q), .hit(dens_hit), .geo(dens_geo)
    );

    // Probe sequencer: ID transaction, optional status transaction, verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= ST_LAUNCH;
            cs_n_q   <= 1'b1;
            kick_q   <= 1'b0;
            tx_q     <= '0;
            byte_q   <= '0;
            id_q     <= '0;
            sr_q     <= '0;
            via_id_q <= 1'b0;
            valid_q  <= 1'b0;
            bad_q    <= 1'b0;
            geo_q    <= '0;
        end else begin
            kick_q <= 1'b0;
            case (phase_q)
                ST_LAUNCH: begin
                    cs_n_q  <= 1'b0;
                    kick_q  <= 1'b1;
                    tx_q    <= OPC_READ_ID;
                    byte_q  <= '0;
                    phase_q <= ST_ID_SHIFT;
                end
                ST_ID_SHIFT: if (x_done) begin
                    if (byte_q != 2'd0) id_q <= {id_q[15:0], x_rx};
                    if (byte_q == 2'(ID_BYTES)) begin
                        cs_n_q  <= 1'b1;
                        phase_q <= ST_ID_JUDGE;
                    end else begin
                        byte_q <= byte_q + 2'd1;
                        kick_q <= 1'b1;
                        tx_q   <= 8'h00;
                    end
                end
                ST_ID_JUDGE: begin
                    if (id_q[23:16] == VENDOR_CODE) begin
                        via_id_q <= 1'b1;
                        if (!id_hit) begin
                            bad_q   <= 1'b1;
                            phase_q <= ST_FINISHED;
                        end else if (id_needs_sr) begin
                            phase_q <= ST_SR_LAUNCH;
                        end else begin
                            geo_q   <= id_geo_odd;
                            valid_q <= 1'b1;
                            phase_q <= ST_FINISHED;
                        end
                    end else begin
                        via_id_q <= 1'b0;
                        phase_q  <= ST_SR_LAUNCH;
                    end
                end
                ST_SR_LAUNCH: begin
                    cs_n_q  <= 1'b0;
                    kick_q  <= 1'b1;
                    tx_q    <= OPC_STATUS;
                    byte_q  <= '0;
                    phase_q <= ST_SR_SHIFT;
                end
                ST_SR_SHIFT: if (x_done) begin
                    if (byte_q == 2'd1) begin
                        sr_q    <= x_rx;
                        cs_n_q  <= 1'b1;
                        phase_q <= ST_SR_JUDGE;
                    end else begin
                        byte_q <= 2'd1;
                        kick_q <= 1'b1;
                        tx_q   <= 8'h00;
                    end
                end
                ST_SR_JUDGE: begin
                    phase_q <= ST_FINISHED;
                    if (via_id_q) begin
                        geo_q   <= sr_q[0] ? id_geo_pow2 : id_geo_odd;
                        valid_q <= 1'b1;
                    end else if (dens_hit) begin
                        geo_q   <= dens_geo;
                        valid_q <= 1'b1;
                    end else begin
                        bad_q <= 1'b1;
                    end
                end
                default: phase_q <= ST_FINISHED;
            endcase
        end
    end

    assign spi_cs_n        = cs_n_q;
    assign geo_valid       = valid_q;
    assign dev_unsupported = bad_q;
    assign found_by_id     = via_id_q & valid_q;
    assign geo_pages       = geo_q.pages;
    assign geo_page_bytes  = geo_q.bytes;
    assign geo_addr_shift  = geo_q.shift;
endmodule

// File: rtl/flash_id_probe_chk.sv
// Property checker for flash_id_probe, attached with bind below.
module flash_id_probe_chk
    import flashid_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               spi_cs_n,
    input logic               spi_sck,
    input logic               spi_mosi,
    input logic               geo_valid,
    input logic               dev_unsupported,
    input logic               found_by_id,
    input logic [PAGES_W-1:0] geo_pages,
    input logic [BYTES_W-1:0] geo_page_bytes,
    input logic [SHIFT_W-1:0] geo_addr_shift
);
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(geo_valid && dev_unsupported));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(geo_valid) |-> (geo_valid && $stable(geo_pages)
                              && $stable(geo_page_bytes) && $stable(geo_addr_shift)));

    p_error_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dev_unsupported) |-> dev_unsupported);

    p_bus_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (geo_valid || dev_unsupported) |-> spi_cs_n);

    p_size_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        geo_valid |-> ((int'(geo_page_bytes) == (1 << geo_addr_shift)) ||
                       (int'(geo_page_bytes) == ((1 << (geo_addr_shift - 1)) +
                                                 (1 << (geo_addr_shift - 6))))));

    p_fallback_odd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (geo_valid && !found_by_id) |-> (int'(geo_page_bytes) != (1 << geo_addr_shift)));
endmodule

bind flash_id_probe flash_id_probe_chk u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .geo_valid(geo_valid), .dev_unsupported(dev_unsupported),
    .found_by_id(found_by_id), .geo_pages(geo_pages),
    .geo_page_bytes(geo_page_bytes), .geo_addr_shift(geo_addr_shift)
);

// File: tb/tb_flash_id_probe.sv
`timescale 1ns/1ps
module tb_flash_id_probe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_miso;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        geo_valid, dev_unsupported, found_by_id;
    logic [13:0] geo_pages;
    logic [10:0] geo_page_bytes;
    logic [3:0]  geo_addr_shift;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    flash_id_probe dut (
        .clk(clk), .rst_n(rst_n), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .geo_valid(geo_valid),
        .dev_unsupported(dev_unsupported), .found_by_id(found_by_id),
        .geo_pages(geo_pages), .geo_page_bytes(geo_page_bytes),
        .geo_addr_shift(geo_addr_shift)
    );

    // Behavioural flash: answers 0x9F with three ID bytes, 0xD7 with status.
    logic [7:0] m_mfr = 8'h1F, m_d1 = 8'h22, m_d2 = 8'h00, m_sr = 8'h00;
    logic [7:0] oplog [0:255];
    int         m_txn = 0;
    int         m_edges = 0;
    logic [7:0] m_op = 8'h00;
    logic       p_cs = 1'b1, p_sck = 1'b0;
    initial spi_miso = 1'b0;

    always @(negedge clk) begin
        if (p_cs && !spi_cs_n) begin
            m_edges = 0;
            m_op = 8'h00;
            m_txn = m_txn + 1;
            spi_miso = 1'b0;
        end else if (!spi_cs_n && !p_sck && spi_sck) begin
            if (m_edges < 8) m_op = {m_op[6:0], spi_mosi};
            m_edges = m_edges + 1;
            if (m_edges == 8) oplog[m_txn & 255] = m_op;
        end else if (!spi_cs_n && p_sck && !spi_sck && m_edges >= 8) begin
            if (m_op == 8'h9F && (m_edges - 8) < 24)
                spi_miso = ({m_mfr, m_d1, m_d2} >> (23 - (m_edges - 8))) & 24'h1;
            else if (m_op == 8'hD7)
                spi_miso = m_sr[7 - ((m_edges - 8) % 8)];
            else
                spi_miso = 1'b0;
        end
        p_cs = spi_cs_n;
        p_sck = spi_sck;
    end

    typedef struct {
        bit ok; bit bad; int pages; int bytes; int shift; bit byid; int ntxn;
    } exp_t;

    // Expected outcome from the requirement tables (R3..R8, R10).
    function automatic exp_t predict(logic [7:0] mfr, logic [7:0] d1, logic [7:0] d2, logic [7:0] sr);
        exp_t e;
        int cls;
        e = '{0, 0, 0, 0, 0, 0, 1};
        if (mfr == 8'h1F) begin
            e.byid = 1;
            cls = -1;
            case (d1)
                8'h22: begin e.pages = 512;  cls = 0; end
                8'h23: begin e.pages = 1024; cls = 0; end
                8'h24: begin e.pages = 2048; cls = 0; end
                8'h25: begin e.pages = 4096; cls = 0; end
                8'h26: begin e.pages = 4096; cls = 1; end
                8'h27: begin e.pages = 8192; cls = 1; end
                8'h28: begin e.pages = 8192; cls = 2; end
                default: cls = -1;
            endcase
            if (cls < 0 || !(d2 == 8'h00 || (d1 == 8'h27 && d2 == 8'h01))) begin
                e.bad = 1; e.pages = 0;
            end else if (d1 == 8'h27 && d2 == 8'h00) begin
                e.ok = 1; e.bytes = 528; e.shift = 10;
            end else begin
                e.ok = 1; e.ntxn = 2;
                if (sr[0]) begin e.bytes = 256 * (1 << cls); e.shift = 8 + cls; end
                else       begin e.bytes = 264 * (1 << cls); e.shift = 9 + cls; end
            end
        end else begin
            e.ntxn = 2;
            if (sr == 8'h00 || sr == 8'hFF) e.bad = 1;
            else case (sr & 8'h3C)
                8'h0C: e = '{1, 0, 512,  264,  9,  0, 2};
                8'h14: e = '{1, 0, 1024, 264,  9,  0, 2};
                8'h1C: e = '{1, 0, 2048, 264,  9,  0, 2};
                8'h24: e = '{1, 0, 4096, 264,  9,  0, 2};
                8'h2C: e = '{1, 0, 4096, 528,  10, 0, 2};
                8'h34: e = '{1, 0, 8192, 528,  10, 0, 2};
                8'h38, 8'h3C: e = '{1, 0, 8192, 1056, 11, 0, 2};
                default: e.bad = 1;
            endcase
        end
        if (e.bad) e.byid = 0;
        return e;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One probe: program the flash model, reset, run, compare.
    task automatic run_case(input logic [7:0] mfr, input logic [7:0] d1,
                            input logic [7:0] d2, input logic [7:0] sr, input bit first);
        exp_t e;
        int base, waited;
        e = predict(mfr, d1, d2, sr);
        @(negedge clk);
        rst_n = 1'b0;
        m_mfr = mfr; m_d1 = d1; m_d2 = d2; m_sr = sr;
        repeat (3) @(negedge clk);
        if (first) begin
            chk("R11", "valid in reset", int'(geo_valid), 0);
            chk("R11", "unsupported in reset", int'(dev_unsupported), 0);
            chk("R2", "cs_n in reset", int'(spi_cs_n), 1);
            chk("R2", "sck in reset", int'(spi_sck), 0);
        end
        base = m_txn;
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1", "cs low after release", int'(spi_cs_n), 0);
        chk("R11", "no verdict mid-probe", int'(geo_valid | dev_unsupported), 0);
        waited = 0;
        while (!(geo_valid || dev_unsupported) && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        repeat (4) @(negedge clk);
        chk("R9", "valid", int'(geo_valid), int'(e.ok));
        chk("R8", "unsupported", int'(dev_unsupported), int'(e.bad));
        if (e.ok) begin
            chk("R4", "pages", int'(geo_pages), e.pages);
            chk("R3", "page bytes", int'(geo_page_bytes), e.bytes);
            chk("R6", "shift", int'(geo_addr_shift), e.shift);
            chk("R10", "found_by_id", int'(found_by_id), int'(e.byid));
        end
        chk("R5", "transactions", m_txn - base, e.ntxn);
        chk("R1", "first opcode", int'(oplog[(base + 1) & 255]), 8'h9F);
        if (e.ntxn == 2) chk("R6", "second opcode", int'(oplog[(base + 2) & 255]), 8'hD7);
        repeat (20) @(negedge clk);
        chk("R9", "held pages", int'(geo_pages), e.ok ? e.pages : 0);
        chk("R9", "held flags", int'({geo_valid, dev_unsupported}), int'({e.ok, e.bad}));
        chk("R9", "cs idle after verdict", int'(spi_cs_n), 1);
    endtask

    initial begin
        logic [7:0] r_mfr, r_d1, r_d2, r_sr;
        void'($urandom(32'h1D5EED));
        run_case(8'h1F, 8'h22, 8'h00, 8'h81, 1);   // R3 binary 256
        run_case(8'h1F, 8'h22, 8'h00, 8'h80, 0);   // R3 non-binary 264
        for (int d = 8'h23; d <= 8'h28; d++) begin // R4 each family both ways
            run_case(8'h1F, 8'(d), 8'h00, 8'h01, 0);
            run_case(8'h1F, 8'(d), 8'h00, 8'hFE, 0);
        end
        run_case(8'h1F, 8'h27, 8'h01, 8'h01, 0);   // R4 0x2701 binary
        run_case(8'h1F, 8'h27, 8'h00, 8'hFF, 0);   // R5 bit0 ignored, no status read
        run_case(8'h1F, 8'h29, 8'h00, 8'h01, 0);   // R8 unlisted family
        run_case(8'h1F, 8'h22, 8'h01, 8'h01, 0);   // R8 unlisted variant
        run_case(8'h00, 8'h22, 8'h00, 8'h0C, 0);   // R6 fallback codes
        run_case(8'hC2, 8'h00, 8'h00, 8'h95, 0);
        run_case(8'h1E, 8'h00, 8'h00, 8'h1F, 0);
        run_case(8'h00, 8'h00, 8'h00, 8'hA4, 0);
        run_case(8'hFF, 8'hFF, 8'hFF, 8'h2D, 0);
        run_case(8'h00, 8'h00, 8'h00, 8'h34, 0);
        run_case(8'h00, 8'h00, 8'h00, 8'h38, 0);
        run_case(8'h00, 8'h00, 8'h00, 8'hBC, 0);
        run_case(8'h00, 8'h00, 8'h00, 8'h00, 0);   // R7 no device
        run_case(8'hFF, 8'hFF, 8'hFF, 8'hFF, 0);   // R7 no device
        run_case(8'h00, 8'h00, 8'h00, 8'h84, 0);   // R8 unlisted density
        for (int i = 0; i < 30; i++) begin
            r_mfr = ($urandom % 4 != 0) ? 8'h1F : 8'($urandom);
            r_d1  = 8'(8'h20 + $urandom % 10);
            r_d2  = ($urandom % 3 == 0) ? 8'($urandom % 2) : 8'h00;
            r_sr  = 8'($urandom);
            run_case(r_mfr, r_d1, r_d2, r_sr, 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule